// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block identifies the parallel NOR flash attached to it. A one-cycle `start` launches a fixed sequence of bus accesses. First comes a reset command to the first unlock address, then a snapshot read of the word at the device base. Next it sends the three-write unlock that enters ID mode and reads the manufacturer code and three device-ID words. Finally it writes the exit command to the base and polls the base word until it matches the snapshot again. The poll also ends if the retry budget runs out.

The three device-ID words are then compared with a parameter table of supported parts. Each table entry is either a short entry, which compares only the first device-ID word, or a long entry, which compares all three. The lowest-numbered hit wins. For a hit, the block reports the entry index, the erase-block size, and the block count and address span, both scaled by the number of devices chained in series. If nothing matches, the found flag is clear and the geometry outputs are zero.

The flash side is a simple strobe interface. Each read or write holds its strobe, address and data for `ACC_CYC` clocks, then drops all strobes for one clock before the next access begins. The `byte_mode` strap selects the address set for a part wired in byte mode.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `poll_timeout`, `mem_we` and `mem_re` are 0.
- R2: A probe opens with a write of 0x00F0 to the first unlock address, followed by a read of address 0 whose value is kept as the snapshot.
- R3: Entry to ID mode is three writes: 0x00AA to the first unlock address, 0x0055 to the second, then 0x0090 to the first. The unlock addresses are 0x555/0x2AA when `byte_mode`=0 and 0xAAA/0x555 when `byte_mode`=1.
- R4: The ID reads happen in this order: manufacturer, device word 1, device word 2, device word 3. With `byte_mode`=0 they use addresses 0, 1, 0x0E, 0x0F. With `byte_mode`=1 they use 0, 2, 0x1C, 0x1E. The values read appear on `mfr_id`, `dev_id1`, `dev_id2`, `dev_id3`.
- R5: In the cycle after an accepted `start`, all four ID outputs are all ones. An ID read therefore only changes an output by returning data.
- R6: After the ID reads, the block writes 0x00F0 to address 0, then reads address 0 repeatedly until a read equals the snapshot. If the match comes within the budget, `poll_timeout` stays 0.
- R7: If `POLL_MAX` consecutive poll reads all differ from the snapshot, polling stops after exactly `POLL_MAX` reads and `poll_timeout` is 1 at `done`.
- R8: A short entry (its bit clear in `TBL_LONG`) matches when `dev_id1` equals its first ID. A long entry also needs `dev_id2` and `dev_id3` to match. When several entries match, the lowest index is reported.
- R9: With no matching entry, `found`=0 and `match_idx`, `blk_size`, `blk_count` and `dev_span` are all 0 at `done`.
- R10: `blk_size` is the entry's block size. `blk_count` and `dev_span` are the entry's values multiplied by `SERIES`.
- R11: `done` is high for exactly one clock, in the same cycle as the new results. Results hold until the next accepted `start`. A `start` while `busy` has no effect on the access sequence.
- R12: Each access holds its strobe for exactly `ACC_CYC` clocks and is followed by at least one clock with both strobes low. `mem_we` and `mem_re` are never high together. `mem_rdata` is sampled in the last strobe clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a probe when idle |
| byte_mode | input | 1 | Selects byte-mode address set; hold stable during a probe |
| mem_addr | output | AW | Flash word address |
| mem_wdata | output | DW | Flash write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | DW | Flash read data |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A table entry matched |
| match_idx | output | IW | Index of the matched entry |
| blk_size | output | 32 | Erase-block size of the matched part |
| blk_count | output | 32 | Block count times SERIES |
| dev_span | output | 32 | Device span times SERIES |
| mfr_id | output | DW | Manufacturer code read |
| dev_id1 | output | DW | Device ID word 1 |
| dev_id2 | output | DW | Device ID word 2 |
| dev_id3 | output | DW | Device ID word 3 |
| poll_timeout | output | 1 | Return to read mode was not seen within POLL_MAX reads |

## Verification
The hardest case to reach from the ports is a return to read mode that is late or never arrives. The first is a poll that succeeds only after several mismatching reads. The second is a poll that runs out its budget exactly.

The bench's flash model returns the inverted snapshot for a programmable number of base reads after the exit command. The scoreboard expects exactly that many reads plus one, or `POLL_MAX` reads when the hold count exceeds the budget.

Priority among table entries is reached with one ID set that satisfies both a long entry and a later short entry. A second set fails only the long entry's third word, so the short entry wins.

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int DW       = 16,
  parameter int AW       = 12,
  parameter int ACC_CYC  = 2,
  parameter int POLL_MAX = 500000,
  parameter int SERIES   = 1,
  parameter int NDEV     = 3,
  parameter logic [NDEV-1:0]    TBL_LONG  = 3'b010,
  parameter logic [NDEV*DW-1:0] TBL_ID1   = {16'h227E, 16'h227E, 16'h22C4},
  parameter logic [NDEV*DW-1:0] TBL_ID2   = {16'h0000, 16'h2210, 16'h0000},
  parameter logic [NDEV*DW-1:0] TBL_ID3   = {16'h0000, 16'h2200, 16'h0000},
  parameter logic [NDEV*32-1:0] TBL_BSIZE = {32'h2000, 32'h10000, 32'h10000},
  parameter logic [NDEV*32-1:0] TBL_BCNT  = {32'd8, 32'd128, 32'd64},
  parameter logic [NDEV*32-1:0] TBL_SPAN  = {32'h10000, 32'h800000, 32'h400000},
  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          byte_mode,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [IW-1:0] match_idx,
  output logic [31:0]   blk_size,
  output logic [31:0]   blk_count,
  output logic [31:0]   dev_span,
  output logic [DW-1:0] mfr_id,
  output logic [DW-1:0] dev_id1,
  output logic [DW-1:0] dev_id2,
  output logic [DW-1:0] dev_id3,
  output logic          poll_timeout
);
  localparam int CW = $clog2(ACC_CYC + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [3:0] ST_POLL  = 4'd10;
  localparam logic [3:0] ST_MATCH = 4'd11;

  logic [3:0]    step;
  logic [CW-1:0] cyc;
  logic [PW-1:0] poll_cnt;
  logic [DW-1:0] snap;
  logic          poll_hit;

  logic          op_we, op_re;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [AW-1:0] ul1, ul2;

  assign ul1 = byte_mode ? AW'(12'hAAA) : AW'(12'h555);
  assign ul2 = byte_mode ? AW'(12'h555) : AW'(12'h2AA);

  always_comb begin
    op_we = 1'b0; op_re = 1'b0; op_addr = '0; op_data = '0;
    case (step)
      4'd0: begin op_we = 1'b1; op_addr = ul1; op_data = DW'(8'hF0); end
      4'd1: op_re = 1'b1;
      4'd2: begin op_we = 1'b1; op_addr = ul1; op_data = DW'(8'hAA); end
      4'd3: begin op_we = 1'b1; op_addr = ul2; op_data = DW'(8'h55); end
      4'd4: begin op_we = 1'b1; op_addr = ul1; op_data = DW'(8'h90); end
      4'd5: op_re = 1'b1;
      4'd6: begin op_re = 1'b1; op_addr = byte_mode ? AW'(2)     : AW'(1);     end
      4'd7: begin op_re = 1'b1; op_addr = byte_mode ? AW'(8'h1C) : AW'(8'h0E); end
      4'd8: begin op_re = 1'b1; op_addr = byte_mode ? AW'(8'h1E) : AW'(8'h0F); end
      4'd9: begin op_we = 1'b1; op_data = DW'(8'hF0); end
      ST_POLL: op_re = 1'b1;
      default: ;
    endcase
  end

  logic strobe_on, acc_last, acc_gap;
  assign strobe_on = busy && (step != ST_MATCH) && (cyc < CW'(ACC_CYC));
  assign acc_last  = (cyc == CW'(ACC_CYC - 1));
  assign acc_gap   = (cyc == CW'(ACC_CYC));
  assign mem_we    = strobe_on && op_we;
  assign mem_re    = strobe_on && op_re;
  assign mem_addr  = strobe_on ? op_addr : '0;
  assign mem_wdata = mem_we ? op_data : '0;

  logic          m_found;
  logic [IW-1:0] m_idx;
  logic [31:0]   m_bsize, m_bcnt, m_span;

  always_comb begin
    m_found = 1'b0; m_idx = '0; m_bsize = '0; m_bcnt = '0; m_span = '0;
    for (int i = NDEV - 1; i >= 0; i--) begin
      if (dev_id1 == TBL_ID1[i*DW +: DW] &&
          (!TBL_LONG[i] || (dev_id2 == TBL_ID2[i*DW +: DW] && dev_id3 == TBL_ID3[i*DW +: DW]))) begin
        m_found = 1'b1;
        m_idx   = IW'(i);
        m_bsize = TBL_BSIZE[i*32 +: 32];
        m_bcnt  = 32'(TBL_BCNT[i*32 +: 32] * SERIES);
        m_span  = 32'(TBL_SPAN[i*32 +: 32] * SERIES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; step <= '0; cyc <= '0; poll_cnt <= '0;
      snap <= '0; poll_hit <= 1'b0; poll_timeout <= 1'b0;
      found <= 1'b0; match_idx <= '0; blk_size <= '0; blk_count <= '0; dev_span <= '0;
      mfr_id <= '0; dev_id1 <= '0; dev_id2 <= '0; dev_id3 <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; step <= '0; cyc <= '0; poll_cnt <= '0; poll_timeout <= 1'b0;
          mfr_id <= '1; dev_id1 <= '1; dev_id2 <= '1; dev_id3 <= '1;
        end
      end else if (step == ST_MATCH) begin
        busy <= 1'b0; done <= 1'b1;
        found <= m_found; match_idx <= m_idx;
        blk_size <= m_bsize; blk_count <= m_bcnt; dev_span <= m_span;
      end else begin
        if (acc_last && op_re) begin
          case (step)
            4'd1:    snap     <= mem_rdata;
            4'd5:    mfr_id   <= mem_rdata;
            4'd6:    dev_id1  <= mem_rdata;
            4'd7:    dev_id2  <= mem_rdata;
            4'd8:    dev_id3  <= mem_rdata;
            default: poll_hit <= (mem_rdata == snap);
          endcase
        end
        if (acc_gap) begin
          cyc <= '0;
          if (step == ST_POLL && !poll_hit) begin
            if (poll_cnt == PW'(POLL_MAX - 1)) begin
              poll_timeout <= 1'b1;
              step <= ST_MATCH;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end else begin
            step <= step + 4'd1;
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R12
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mem_we || mem_re) |-> busy); // R12
  AST_ID_PRESET:   assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (mfr_id == '1 && dev_id1 == '1 && dev_id2 == '1 && dev_id3 == '1)); // R5
  AST_TIMEOUT_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(poll_timeout) |=> done); // R7
  AST_MISS_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (done && !found) |-> (blk_count == 0 && blk_size == 0 && dev_span == 0 && match_idx == 0)); // R9
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> ($stable(found) && $stable(match_idx) && $stable(blk_count) && $stable(dev_id1))); // R11
endmodule

// File: tb/sim_flash_id_probe.sv
module sim_flash_id_probe;
  localparam int DW = 16, AW = 12, ACC = 3, PM = 8, SER = 2;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_mode = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, mfr_id, dev_id1, dev_id2, dev_id3;
  logic mem_we, mem_re, busy, done, found, poll_timeout;
  logic [IW-1:0] match_idx;
  logic [31:0] blk_size, blk_count, dev_span;

  always #4 clk = ~clk;

  flash_id_probe #(.DW(DW), .AW(AW), .ACC_CYC(ACC), .POLL_MAX(PM), .SERIES(SER)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .found(found), .match_idx(match_idx),
    .blk_size(blk_size), .blk_count(blk_count), .dev_span(dev_span),
    .mfr_id(mfr_id), .dev_id1(dev_id1), .dev_id2(dev_id2), .dev_id3(dev_id3),
    .poll_timeout(poll_timeout));

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model
  logic [DW-1:0] m_base = 16'h3C5A, m_mfr, m_id1, m_id2, m_id3;
  int  hold = 0, pending = 0;
  logic autosel = 1'b0;

  always_comb begin
    if (autosel) begin
      if (mem_addr == 0)                                 mem_rdata = m_mfr;
      else if (mem_addr == (byte_mode ? 12'h2 : 12'h1))  mem_rdata = m_id1;
      else if (mem_addr == (byte_mode ? 12'h1C : 12'hE)) mem_rdata = m_id2;
      else if (mem_addr == (byte_mode ? 12'h1E : 12'hF)) mem_rdata = m_id3;
      else                                               mem_rdata = 16'h0000;
    end else if (mem_addr == 0) mem_rdata = (pending > 0) ? ~m_base : m_base;
    else mem_rdata = 16'h5A5A;
  end

  // scoreboard
  logic [AW+DW:0] exp_q[$];
  string tag_q[$];

  task automatic expect_acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    exp_q.push_back({we, a, d});
    tag_q.push_back(tag);
  endtask

  logic prev_acc = 1'b0, cur_we = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  int len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((mem_we || mem_re) && !prev_acc) begin
        if (exp_q.size() == 0) chk("R11 unexpected access", {mem_we, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
        else begin
          logic [AW+DW:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, 32'({mem_we, mem_addr, mem_wdata}), 32'(e));
        end
        chk("R12 no dual strobe", {31'd0, mem_we && mem_re}, 32'd0);
        cur_we = mem_we; cur_addr = mem_addr; len = 1;
        if (mem_we) begin
          if (mem_wdata == 16'h0090) autosel = 1'b1;
          if (mem_wdata == 16'h00F0) begin
            autosel = 1'b0;
            pending = (mem_addr == 0) ? hold : 0;
          end
        end
      end else if (mem_we || mem_re) len++;
      if (!(mem_we || mem_re) && prev_acc) begin
        chk("R12 strobe length", len, ACC);
        if (!cur_we && cur_addr == 0 && !autosel && pending > 0) pending--;
      end
      prev_acc = mem_we || mem_re;
    end
  end

  task automatic run_probe(input logic [DW-1:0] mf, i1, i2, i3, input int hp, input logic bm, input bit extra);
    logic [AW-1:0] a1, a2;
    int polls;
    m_mfr = mf; m_id1 = i1; m_id2 = i2; m_id3 = i3; hold = hp; byte_mode = bm;
    a1 = bm ? 12'hAAA : 12'h555;
    a2 = bm ? 12'h555 : 12'h2AA;
    expect_acc(1, a1, 16'h00F0, "R2 pre-reset");
    expect_acc(0, 0, 0, "R2 snapshot read");
    expect_acc(1, a1, 16'h00AA, "R3 unlock 1");
    expect_acc(1, a2, 16'h0055, "R3 unlock 2");
    expect_acc(1, a1, 16'h0090, "R3 id entry");
    expect_acc(0, 0, 0, "R4 mfr read");
    expect_acc(0, bm ? 12'h2 : 12'h1, 0, "R4 id1 read");
    expect_acc(0, bm ? 12'h1C : 12'hE, 0, "R4 id2 read");
    expect_acc(0, bm ? 12'h1E : 12'hF, 0, "R4 id3 read");
    expect_acc(1, 0, 16'h00F0, "R6 exit write");
    polls = (hp >= PM) ? PM : hp + 1;
    for (int k = 0; k < polls; k++) expect_acc(0, 0, 0, (hp >= PM) ? "R7 poll read" : "R6 poll read");
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R5 mfr preset", mfr_id, 32'hFFFF);
    chk("R5 id1 preset", dev_id1, 32'hFFFF);
    if (extra) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk("R6 all accesses seen", exp_q.size(), 0);
    chk("R4 mfr value", mfr_id, mf);
    chk("R4 id3 value", dev_id3, i3);
    chk(hp >= PM ? "R7 timeout flag" : "R6 no timeout", poll_timeout, hp >= PM);
  endtask

  task automatic chk_result(input string req, input logic f, input int idx, input logic [31:0] bs, bc, sp);
    chk({req, " found"}, found, f);
    chk({req, " idx"}, match_idx, idx);
    chk("R10 blk_size", blk_size, bs);
    chk("R10 blk_count", blk_count, bc);
    chk("R10 dev_span", dev_span, sp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 found", found, 0);
    chk("R1 strobes", {mem_we, mem_re}, 0);
    chk("R1 timeout", poll_timeout, 0);

    run_probe(16'h0001, 16'h22C4, 16'h0000, 16'h0000, 3, 1'b0, 1'b0);
    chk_result("R8 short", 1, 0, 32'h10000, 32'd128, 32'h800000);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    repeat (5) @(negedge clk);
    chk("R11 hold found", found, 1);
    chk("R11 hold count", blk_count, 128);
    chk("R11 hold id1", dev_id1, 16'h22C4);

    run_probe(16'h0001, 16'h227E, 16'h2210, 16'h2200, 0, 1'b0, 1'b0);
    chk_result("R8 long over later short", 1, 1, 32'h10000, 32'd256, 32'h1000000);

    run_probe(16'h0001, 16'h227E, 16'h2210, 16'h1111, 2, 1'b0, 1'b0);
    chk_result("R8 long miss falls to short", 1, 2, 32'h2000, 32'd16, 32'h20000);

    run_probe(16'h0004, 16'h1111, 16'h2210, 16'h2200, 1, 1'b0, 1'b0);
    chk_result("R9 no match", 0, 0, 0, 0, 0);

    run_probe(16'h00C2, 16'h22C4, 16'h0000, 16'h0000, 2, 1'b1, 1'b0);
    chk_result("R4 byte mode", 1, 0, 32'h10000, 32'd128, 32'h800000);

    run_probe(16'h0001, 16'h22C4, 16'h0000, 16'h0000, 100, 1'b0, 1'b0);
    chk_result("R7 result after timeout", 1, 0, 32'h10000, 32'd128, 32'h800000);

    run_probe(16'h0001, 16'h227E, 16'h2210, 16'h2200, 4, 1'b0, 1'b1);
    chk_result("R11 start while busy", 1, 1, 32'h10000, 32'd256, 32'h1000000);
    repeat (ACC + 3) @(negedge clk);
    chk("R11 no access after done", exp_q.size(), 0);
    chk("R11 idle after done", busy, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule